// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address. It walks a four-level radix page table that sits in memory. The root table's physical base comes in on a port that privileged software sets up. The walker samples that base when it accepts a request.

A request carries the virtual address, a write flag and a user-mode flag. The walker reads one 64-bit entry per level over a valid/ready memory read port. It ends each walk with a one-cycle result. A result is either the physical address with the effective write and user permissions, or a fault. A fault carries the full faulting virtual address and a three-bit error code.

A level-2 entry with its page-size bit set ends the walk early as a 1 GB mapping. Only one walk is ever in flight at a time.

Top module: `page_walker`

## Requirements
- R1: A request whose bits 63:47 are not all equal faults. No memory read is issued, and error code bit 0 is clear.
- R2: Levels are numbered 1 (top) to 4. The level-n read address is the current table base plus 8 times the level's 9-bit index. The index is VA[47:39] for level 1, VA[38:30] for level 2, VA[29:21] for level 3 and VA[20:12] for level 4. The level-1 base is root_base with bits 11:0 and 63:48 cleared.
- R3: A non-leaf entry gives the next table base as entry bits 47:12 followed by twelve zero bits. A successful 4 KB walk makes exactly four reads.
- R4: An entry with bit 0 (present) clear ends the walk at once with a fault, and error code bit 0 is clear.
- R5: A level-2 entry with bit 7 set is a 1 GB leaf. The result is {16'b0, entry[47:30], VA[29:0]}, after exactly two reads. Bit 7 has no effect at any other level.
- R6: A level-4 leaf gives the physical address {16'b0, entry[47:12], VA[11:0]}.
- R7: The effective writable flag is the AND of bit 1 over every entry visited. The effective user flag is the AND of bit 2 over every entry visited. A successful result reports both flags.
- R8: A user-mode request faults when the effective user flag is clear. Error code bit 0 is set.
- R9: A write request faults when the effective writable flag is clear, in either mode. Error code bit 0 is set.
- R10: On a fault, fault_va holds the request's full virtual address. The error code is {user, write, protection}.
- R11: req_ready is low from the accepting edge until the cycle after the result. res_valid is high for exactly one cycle per request.
- R12: While a memory read is waiting for ready, its address stays unchanged. Every read address is 8-byte aligned.
- R13: After reset, req_ready is high and both mem_req_valid and res_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 64 | Physical base of the top-level table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | 64 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Physical address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry value read from memory |
| res_valid | output | 1 | One-cycle result strobe |
| res_fault | output | 1 | Result is a fault |
| res_pa | output | 64 | Translated physical address |
| res_writable | output | 1 | Effective writable permission |
| res_user | output | 1 | Effective user permission |
| fault_va | output | 64 | Virtual address that faulted |
| fault_code | output | 3 | {user, write, protection} |

## Verification
The bench uses three kinds of 4 KB page: full-permission, read-only-user and kernel-only. Each is tried under every combination of write and user mode, which separates the user-bit fault from the write-bit fault and from a successful result. A separate region has a restrictive upper-level entry above a permissive leaf, which shows that permissions are ANDed across levels rather than taken from the leaf alone. A 1 GB mapping with a large offset tests the short-circuit and the 30-bit offset splice. Unmapped and non-canonical addresses near the sign-extension boundary test the present-bit and canonical checks through the read count. Random addresses drawn from the mapped regions and from the whole 64-bit space are compared, read by read, against a bench-side walk of the same table image.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W     = 64;
  localparam int PA_W     = 64;
  localparam int ADDR_USE = 48;
  localparam int LVLS     = 4;
  localparam int IDX_W    = 9;
  localparam int OFF_W    = 12;
  localparam int ENT_SH   = 3;
  localparam int HUGE_LVL = 1;
  localparam int BIT_P    = 0;
  localparam int BIT_W    = 1;
  localparam int BIT_U    = 2;
  localparam int BIT_PS   = 7;
  localparam int LVL_W    = $clog2(LVLS);
  localparam int RDC_W    = $clog2(LVLS + 1);
  localparam logic [PA_W-1:0] USE_MASK  = (PA_W'(1) << ADDR_USE) - PA_W'(1);
  localparam logic [PA_W-1:0] PAGE_MASK = (PA_W'(1) << OFF_W) - PA_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} walk_state_t;

  function automatic logic is_canonical(logic [VA_W-1:0] va);
    logic [VA_W-ADDR_USE:0] hi;
    hi = va[VA_W-1:ADDR_USE-1];
    return (&hi) || !(|hi);
  endfunction

  function automatic int unsigned level_shift(logic [LVL_W-1:0] lvl);
    return OFF_W + IDX_W * (LVLS - 1 - int'(lvl));
  endfunction

  function automatic logic [IDX_W-1:0] level_index(logic [VA_W-1:0] va, logic [LVL_W-1:0] lvl);
    return IDX_W'(va >> level_shift(lvl));
  endfunction

  function automatic logic [PA_W-1:0] entry_addr(logic [PA_W-1:0] base, logic [IDX_W-1:0] idx);
    return base + (PA_W'(idx) << ENT_SH);
  endfunction

  function automatic logic [PA_W-1:0] table_base(logic [PA_W-1:0] raw);
    return raw & USE_MASK & ~PAGE_MASK;
  endfunction

  function automatic logic [PA_W-1:0] leaf_pa(logic [PA_W-1:0] pte, logic [VA_W-1:0] va,
                                               logic [LVL_W-1:0] lvl);
    logic [PA_W-1:0] low;
    low = (PA_W'(1) << level_shift(lvl)) - PA_W'(1);
    return (pte & USE_MASK & ~low) | (PA_W'(va) & low);
  endfunction

  function automatic logic [2:0] fault_code_of(logic prot, logic wr, logic usr);
    return {usr, wr, prot};
  endfunction
endpackage

// File: rtl/ptw_index_gen.sv
module ptw_index_gen
  import ptw_pkg::*;
(
  input  logic [PA_W-1:0]  base,
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] lvl,
  output logic [PA_W-1:0]  addr
);
  logic [IDX_W-1:0] idx;
  always_comb begin
    idx  = level_index(va, lvl);
    addr = entry_addr(base, idx);
  end
endmodule

// File: rtl/ptw_perm_acc.sv
module ptw_perm_acc
  import ptw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic load,
  input  logic ent_w,
  input  logic ent_u,
  output logic eff_w,
  output logic eff_u
);
  logic acc_w, acc_u;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      acc_w <= 1'b1;
      acc_u <= 1'b1;
    end else if (load) begin
      acc_w <= acc_w & ent_w;
      acc_u <= acc_u & ent_u;
    end
  end

  assign eff_w = acc_w & ent_w;
  assign eff_u = acc_u & ent_u;

  // R7
  sticky_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear && !ent_w) |=> !eff_w);
  // R7
  sticky_u_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear && !ent_u) |=> !eff_u);
endmodule

// File: rtl/ptw_leaf_check.sv
module ptw_leaf_check
  import ptw_pkg::*;
(
  input  logic eff_w,
  input  logic eff_u,
  input  logic is_wr,
  input  logic is_usr,
  output logic grant
);
  logic user_block, write_block;
  always_comb begin
    user_block  = is_usr && !eff_u;
    write_block = is_wr && !eff_w;
    grant       = !user_block && !write_block;
  end
endmodule

// File: rtl/page_walker.sv
module page_walker
  import ptw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PA_W-1:0] root_base,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_va,
  input  logic            req_write,
  input  logic            req_user,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [PA_W-1:0] mem_rsp_data,
  output logic            res_valid,
  output logic            res_fault,
  output logic [PA_W-1:0] res_pa,
  output logic            res_writable,
  output logic            res_user,
  output logic [VA_W-1:0] fault_va,
  output logic [2:0]      fault_code
);
  walk_state_t      state;
  logic [LVL_W-1:0] lvl;
  logic [PA_W-1:0]  base_q;
  logic [VA_W-1:0]  va_q;
  logic             wr_q, usr_q;
  logic [RDC_W-1:0] rd_cnt;

  // named internal events
  logic req_fire, mem_hs, rsp_fire, va_noncanon, canon_reject;
  logic pte_present, pte_leaf, step_down, eff_w, eff_u, grant;

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_ISSUE);
  assign res_valid     = (state == S_DONE);
  assign req_fire      = req_valid && req_ready;
  assign mem_hs        = mem_req_valid && mem_req_ready;
  assign rsp_fire      = (state == S_WAIT) && mem_rsp_valid;
  assign va_noncanon   = !is_canonical(req_va);
  assign canon_reject  = req_fire && va_noncanon;
  assign pte_present   = mem_rsp_data[BIT_P];
  assign pte_leaf      = (lvl == LVL_W'(LVLS - 1)) ||
                         ((lvl == LVL_W'(HUGE_LVL)) && mem_rsp_data[BIT_PS]);
  assign step_down     = rsp_fire && pte_present && !pte_leaf;

  ptw_index_gen u_idx (
    .base (base_q),
    .va   (va_q),
    .lvl  (lvl),
    .addr (mem_req_addr)
  );

  ptw_perm_acc u_perm (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (req_fire),
    .load  (step_down),
    .ent_w (mem_rsp_data[BIT_W]),
    .ent_u (mem_rsp_data[BIT_U]),
    .eff_w (eff_w),
    .eff_u (eff_u)
  );

  ptw_leaf_check u_chk (
    .eff_w  (eff_w),
    .eff_u  (eff_u),
    .is_wr  (wr_q),
    .is_usr (usr_q),
    .grant  (grant)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rd_cnt <= '0;
    else if (req_fire) rd_cnt <= '0;
    else if (mem_hs) rd_cnt <= rd_cnt + RDC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      lvl          <= '0;
      base_q       <= '0;
      va_q         <= '0;
      wr_q         <= 1'b0;
      usr_q        <= 1'b0;
      res_fault    <= 1'b0;
      res_pa       <= '0;
      res_writable <= 1'b0;
      res_user     <= 1'b0;
      fault_va     <= '0;
      fault_code   <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (req_fire) begin
          va_q   <= req_va;
          wr_q   <= req_write;
          usr_q  <= req_user;
          lvl    <= '0;
          base_q <= table_base(root_base);
          if (va_noncanon) begin
            res_fault    <= 1'b1;
            res_pa       <= '0;
            res_writable <= 1'b0;
            res_user     <= 1'b0;
            fault_va     <= req_va;
            fault_code   <= fault_code_of(1'b0, req_write, req_user);
            state        <= S_DONE;
          end else begin
            state <= S_ISSUE;
          end
        end
        S_ISSUE: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (!pte_present) begin
            res_fault    <= 1'b1;
            res_pa       <= '0;
            res_writable <= 1'b0;
            res_user     <= 1'b0;
            fault_va     <= va_q;
            fault_code   <= fault_code_of(1'b0, wr_q, usr_q);
            state        <= S_DONE;
          end else if (pte_leaf) begin
            res_writable <= eff_w;
            res_user     <= eff_u;
            if (grant) begin
              res_fault  <= 1'b0;
              res_pa     <= leaf_pa(mem_rsp_data, va_q, lvl);
              fault_code <= '0;
            end else begin
              res_fault  <= 1'b1;
              res_pa     <= '0;
              fault_va   <= va_q;
              fault_code <= fault_code_of(1'b1, wr_q, usr_q);
            end
            state <= S_DONE;
          end else begin
            base_q <= table_base(mem_rsp_data);
            lvl    <= lvl + LVL_W'(1);
            state  <= S_ISSUE;
          end
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1
  canon_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    canon_reject |=> (res_valid && res_fault && !fault_code[0] && !mem_req_valid));
  // R3
  read_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= RDC_W'(LVLS));
  // R7
  grant_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_fault && wr_q) |-> res_writable);
  // R8
  grant_u_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_fault && usr_q) |-> res_user);
  // R11
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || res_valid) |-> !req_ready);
  // R11
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R12
  mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[ENT_SH-1:0] == '0));
endmodule

// File: tb/sim_page_walker.sv
`timescale 1ns/1ps
module sim_page_walker;
  localparam logic [63:0] ROOT = 64'h0000_0000_0000_1000;

  logic        clk, rst_n;
  logic [63:0] root_base;
  logic        req_valid, req_ready, req_write, req_user;
  logic [63:0] req_va;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [63:0] mem_req_addr, mem_rsp_data;
  logic        res_valid, res_fault, res_writable, res_user;
  logic [63:0] res_pa, fault_va;
  logic [2:0]  fault_code;

  page_walker u0 (
    .clk(clk), .rst_n(rst_n), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_write(req_write), .req_user(req_user),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_fault(res_fault),
    .res_pa(res_pa), .res_writable(res_writable), .res_user(res_user),
    .fault_va(fault_va), .fault_code(fault_code)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  logic [63:0] pmem [logic [63:0]];
  logic [63:0] next_tbl = 64'h2000;
  int errors = 0, checks = 0;
  bit finished = 0;
  int rd_n = 0;
  logic [63:0] got_addr [8];
  int busy_bad = 0, pulse_bad = 0;

  bit          e_fault, e_w, e_u;
  logic [2:0]  e_code;
  logic [63:0] e_pa;
  int          e_nrd;
  logic [63:0] e_addr [4];

  bit          g_fault, g_w, g_u;
  logic [2:0]  g_code;
  logic [63:0] g_pa, g_fva;

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rdmem(input logic [63:0] a);
    if (pmem.exists(a)) return pmem[a];
    return 64'h0;
  endfunction

  function automatic logic [8:0] idx9(input logic [63:0] va, input int l);
    case (l)
      0: return va[47:39];
      1: return va[38:30];
      2: return va[29:21];
      default: return va[20:12];
    endcase
  endfunction

  // bench-side walk of the same table image
  task automatic model(input logic [63:0] va, input bit w, input bit u);
    logic [63:0] base, e, a;
    bit ew, eu, done;
    e_nrd = 0; e_fault = 0; e_code = 3'b0; e_pa = '0; e_w = 0; e_u = 0;
    if (!((va[63:47] == '1) || (va[63:47] == '0))) begin
      e_fault = 1; e_code = {u, w, 1'b0};
      return;
    end
    base = ROOT; ew = 1; eu = 1; done = 0;
    for (int l = 0; l < 4 && !done; l++) begin
      a = base + {52'b0, idx9(va, l), 3'b0};
      e_addr[e_nrd] = a;
      e_nrd++;
      e = rdmem(a);
      if (!e[0]) begin
        e_fault = 1; e_code = {u, w, 1'b0}; done = 1;
      end else begin
        ew = ew & e[1];
        eu = eu & e[2];
        if (l == 3 || (l == 1 && e[7])) begin
          if (l == 3) e_pa = {16'b0, e[47:12], va[11:0]};
          else        e_pa = {16'b0, e[47:30], va[29:0]};
          if ((u && !eu) || (w && !ew)) begin
            e_fault = 1; e_code = {u, w, 1'b1};
          end
          e_w = ew; e_u = eu; done = 1;
        end else begin
          base = {16'b0, e[47:12], 12'b0};
        end
      end
    end
  endtask

  function automatic logic [63:0] walk_to(input logic [63:0] va, input int upto,
                                          input logic [63:0] mid);
    logic [63:0] base, a;
    base = ROOT;
    for (int l = 0; l < upto; l++) begin
      a = base + {52'b0, idx9(va, l), 3'b0};
      if (pmem.exists(a) && pmem[a][0]) begin
        base = {16'b0, pmem[a][47:12], 12'b0};
      end else begin
        pmem[a] = next_tbl | mid;
        base = next_tbl;
        next_tbl = next_tbl + 64'h1000;
      end
    end
    return base;
  endfunction

  task automatic map_small(input logic [63:0] va, input logic [63:0] pa,
                           input logic [63:0] mid, input logic [63:0] leaf);
    logic [63:0] t;
    t = walk_to(va, 3, mid);
    pmem[t + {52'b0, idx9(va, 3), 3'b0}] = {16'b0, pa[47:12], 12'b0} | leaf;
  endtask

  task automatic map_huge(input logic [63:0] va, input logic [63:0] pa,
                          input logic [63:0] mid, input logic [63:0] leaf);
    logic [63:0] t;
    t = walk_to(va, 1, mid);
    pmem[t + {52'b0, idx9(va, 1), 3'b0}] = {16'b0, pa[47:30], 30'b0} | leaf | 64'h80;
  endtask

  // memory responder
  initial begin
    logic [63:0] pend;
    int cnt;
    cnt = 0; pend = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rdmem(pend);
        end
      end
      mem_req_ready = ($urandom % 4) != 0;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        pend = mem_req_addr;
        if (rd_n < 8) got_addr[rd_n] = mem_req_addr;
        rd_n++;
        cnt = 1 + int'($urandom % 3);
      end
    end
  end

  task automatic xlate(input logic [63:0] va, input bit w, input bit u);
    int guard;
    rd_n = 0;
    @(negedge clk);
    req_va = va; req_write = w; req_user = u; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!res_valid && guard < 300) begin
      if (req_ready) busy_bad++;
      @(negedge clk);
      guard++;
    end
    chk(res_valid, "R11", "result strobe seen", {63'b0, res_valid}, 64'h1);
    g_fault = res_fault; g_pa = res_pa; g_w = res_writable; g_u = res_user;
    g_fva = fault_va; g_code = fault_code;
    @(negedge clk);
    if (res_valid || !req_ready) pulse_bad++;
  endtask

  task automatic run(input logic [63:0] va, input bit w, input bit u, input string tag);
    model(va, w, u);
    xlate(va, w, u);
    chk(g_fault == e_fault, tag, "fault flag", {63'b0, g_fault}, {63'b0, e_fault});
    if (e_fault) begin
      chk(g_fva == va, "R10", "fault address", g_fva, va);
      chk(g_code == e_code, "R10", "error code", {61'b0, g_code}, {61'b0, e_code});
    end else begin
      chk(g_pa == e_pa, tag, "physical address", g_pa, e_pa);
      chk(g_w == e_w && g_u == e_u, "R7", "permissions",
          {62'b0, g_w, g_u}, {62'b0, e_w, e_u});
    end
    chk(rd_n == e_nrd, "R3", "read count", 64'(rd_n), 64'(e_nrd));
    for (int i = 0; i < e_nrd && i < rd_n; i++)
      chk(got_addr[i] == e_addr[i], "R2", "entry read address", got_addr[i], e_addr[i]);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R11 watchdog: actual=running expected=finished");
    report();
  end

  localparam logic [63:0] VA_A = 64'h0000_0012_3456_7000;
  localparam logic [63:0] VA_B = 64'h0000_0012_3456_8000;
  localparam logic [63:0] VA_C = 64'h0000_0012_3456_9000;
  localparam logic [63:0] VA_D = 64'h0000_0100_4000_0000;
  localparam logic [63:0] VA_E = 64'h0000_7F00_0000_1000;
  localparam logic [63:0] VA_F = 64'hFFFF_8000_0020_0000;

  initial begin
    logic [63:0] pool [6];
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_va = '0; req_write = 1'b0; req_user = 1'b0;
    root_base = ROOT | 64'hFFFF_0000_0000_0ABC;  // junk bits must be masked (R2)

    map_small(VA_A, 64'h0000_0ABC_DEF1_2000, 64'h7, 64'h7);
    map_small(VA_B, 64'h0000_0000_5555_6000, 64'h7, 64'h5);
    map_small(VA_C, 64'h0000_0000_7777_7000, 64'h7, 64'h3);
    map_huge (VA_D, 64'h0000_0003_C000_0000, 64'h7, 64'h7);
    map_small(VA_E, 64'h0000_0000_0BAD_1000, 64'h5, 64'h7);
    map_small(VA_F, 64'h0000_0000_1234_5000, 64'h3, 64'h3);
    pool[0] = VA_A; pool[1] = VA_B; pool[2] = VA_C;
    pool[3] = VA_D; pool[4] = VA_E; pool[5] = VA_F;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13
    chk(req_ready && !mem_req_valid && !res_valid, "R13", "reset outputs",
        {61'b0, req_ready, mem_req_valid, res_valid}, 64'h4);

    run(VA_A | 64'h345, 0, 1, "R6");
    run(VA_A | 64'hFFF, 1, 0, "R6");
    run(VA_B | 64'h10, 1, 1, "R9");
    run(VA_B | 64'h20, 0, 1, "R7");
    run(VA_B, 1, 0, "R9");
    run(VA_C | 64'h8, 0, 1, "R8");
    run(VA_C, 1, 0, "R6");
    run(VA_D + 64'h1234_5678, 0, 1, "R5");
    chk(g_pa == 64'h0000_0003_D234_5678 && rd_n == 2, "R5", "1G leaf address",
        g_pa, 64'h0000_0003_D234_5678);
    run(VA_E | 64'h44, 1, 1, "R7");
    run(VA_E | 64'h44, 0, 1, "R7");
    run(VA_F | 64'h123, 0, 0, "R6");
    run(VA_F, 0, 1, "R8");
    run(64'h0000_0012_4000_0000, 0, 1, "R4");
    run(64'h0000_7FFF_FFFF_FFFF, 1, 0, "R4");
    run(64'h0000_8000_0000_0000, 1, 1, "R1");
    chk(rd_n == 0, "R1", "no read on non-canonical", 64'(rd_n), 64'h0);
    run(64'hFFFF_7FFF_FFFF_F000, 0, 0, "R1");
    run(64'h0001_0000_0000_0000, 0, 1, "R1");

    for (int n = 0; n < 80; n++) begin
      logic [63:0] va;
      int r, p;
      r = int'($urandom % 10);
      if (r < 8) begin
        p = int'($urandom % 6);
        if (p == 3) va = pool[p] + {34'b0, 30'($urandom)};
        else        va = pool[p] + {52'b0, 12'($urandom)};
        if (r == 7) va = va + 64'h20_0000;
      end else begin
        va = {$urandom, $urandom};
        if ($urandom % 2) va = {{16{va[47]}}, va[47:0]};
      end
      run(va, 1'($urandom), 1'($urandom), "R7");
    end

    // R11
    chk(busy_bad == 0, "R11", "req_ready low during walk", 64'(busy_bad), 64'h0);
    chk(pulse_bad == 0, "R11", "single-cycle result then ready", 64'(pulse_bad), 64'h0);
    report();
  end
endmodule